// File: doc/BRIEF.md
# Tamper Event Manager

This block gathers tamper indications from eleven internal source lines and from a set of external pins whose levels are compared against an expected pattern, and turns each enabled event into a sticky flag. Each flag is classified when it is raised. A confirmed event fires a one-cycle erase strobe for the device secrets. A potential event holds the secret storage closed until software clears the flag or sets an override bit. A timestamp strobe accompanies every new event.

A watchdog-fire input that arrives while any potential flag is still pending escalates the situation. It raises internal source 10, and that source is always treated as confirmed. External pins pass through a sample-window filter, so that a single glitchy comparison is not enough to trigger. Software sees a small word-addressed register file. The register file holds the enables, the no-erase bits, the control bits, the read-only flags and the write-one-to-clear words.

Top module: `tamper_event_mgr`

## Requirements
- R1: A source whose enable bit is 0 never raises its flag, whatever its input does. Internal enables sit at address 0, bit i for internal source i. External enables sit at address 2, bit j for pin j.
- R2: An enabled source with its no-erase bit set raises a potential flag and no erase. Internal no-erase bits are at address 1 and external no-erase bits at address 3. With the no-erase bit clear, the source raises a confirmed flag and an erase.
- R3: `erase_o` is high for exactly the one cycle in which a confirmed flag goes from 0 to 1. That flag and `erase_o` appear after the same clock edge.
- R4: Internal position 9 is reserved. Its enable reads back as 0 and its flag never sets.
- R5: When `wdog_fire_i` is high while any potential flag is set, internal flag 10 is raised on the next edge as a confirmed event. This happens regardless of enable bit 10 and no-erase bit 10.
- R6: While any potential flag is set and override (address 4, bit 0) is 0, `block_o` is 1, `store_wr_o` is 0 and `store_rdata_o` is 0. Otherwise the store signals pass straight through.
- R7: `ts_strobe_o` pulses for one cycle whenever any flag goes from 0 to 1.
- R8: `erase_bkram_o` equals `erase_o` when the backup-RAM option (address 4, bit 1) is 1, and is 0 otherwise.
- R9: Flags are sticky. Writing 1s to address 7 (internal) or address 8 (external) clears the matching flags. A source that is still active in the clearing cycle keeps its flag.
- R10: On each `ext_sample_i` cycle, an enabled pin shifts the mismatch `ext_pin_i ^ ext_ref_i` into a four-sample history. The pin triggers once two or more of the last four samples mismatched, and its flag sets one edge later.
- R11: `reg_rdata_o` shows the register at `reg_addr_i` combinationally. Flags are at addresses 5 (internal) and 6 (external), and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| int_tamp_i | input | 11 | Internal tamper source levels |
| ext_pin_i | input | NUM_EXT | External tamper pin levels |
| ext_ref_i | input | NUM_EXT | Expected external pin levels |
| ext_sample_i | input | 1 | Comparison sample strobe |
| wdog_fire_i | input | 1 | Watchdog fire indication |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data |
| store_wr_i | input | 1 | Secret storage write request |
| store_rdata_i | input | SW | Secret storage read data |
| store_wr_o | output | 1 | Gated storage write |
| store_rdata_o | output | SW | Gated storage read data |
| block_o | output | 1 | Storage blocked by a potential tamper |
| erase_o | output | 1 | Secrets erase strobe |
| erase_bkram_o | output | 1 | Backup RAM erase strobe |
| ts_strobe_o | output | 1 | Timestamp capture strobe |

## Verification
The assertions assume that every input is already synchronous to `clk_i` and is held stable for a whole cycle. They also assume that a clear write and a new event on the same bit resolve in favour of the event. The stimulus changes all inputs just after a rising edge and holds them until the next one. The bench drives the watchdog line and the sample strobe as single-cycle pulses, so that each sample window and each escalation can be counted exactly.

// File: rtl/tamper_event_mgr.sv
module tamper_event_mgr #(
  parameter int NUM_EXT   = 4,
  parameter int FILT_LEN  = 4,
  parameter int FILT_HITS = 2,
  parameter int DW        = 16,
  parameter int AW        = 4,
  parameter int SW        = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [10:0]        int_tamp_i,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [NUM_EXT-1:0] ext_ref_i,
  input  logic               ext_sample_i,
  input  logic               wdog_fire_i,
  input  logic               reg_we_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               store_wr_i,
  input  logic [SW-1:0]      store_rdata_i,
  output logic               store_wr_o,
  output logic [SW-1:0]      store_rdata_o,
  output logic               block_o,
  output logic               erase_o,
  output logic               erase_bkram_o,
  output logic               ts_strobe_o
);
  localparam int NI  = 11;
  localparam int RSV = 9;
  localparam int ESC = 10;
  localparam logic [NI-1:0] RSV_MASK = ~(NI'(1) << RSV);
  localparam logic [NI-1:0] ESC_BIT  = NI'(1) << ESC;
  localparam logic [AW-1:0] A_IEN = AW'(0), A_INE = AW'(1), A_EEN = AW'(2), A_ENE = AW'(3),
                            A_CTL = AW'(4), A_IFL = AW'(5), A_EFL = AW'(6),
                            A_ICLR = AW'(7), A_ECLR = AW'(8);

  logic [NI-1:0]      int_en_q, int_ne_q, int_flag_q, int_pot_q;
  logic [NUM_EXT-1:0] ext_en_q, ext_ne_q, ext_flag_q, ext_pot_q;
  logic               ovr_q, bkopt_q, erase_q, bkram_q, ts_q;

  logic               any_pot, escal;
  logic [NI-1:0]      int_set, int_new, int_clr, int_ne_eff;
  logic [NUM_EXT-1:0] ext_set, ext_new, ext_clr;

  assign any_pot    = |(int_flag_q & int_pot_q) | |(ext_flag_q & ext_pot_q);
  assign escal      = wdog_fire_i & any_pot;
  assign int_set    = (int_tamp_i & int_en_q & RSV_MASK) | (escal ? ESC_BIT : '0);
  assign int_ne_eff = int_ne_q & ~ESC_BIT;
  assign int_new    = int_set & ~int_flag_q;
  assign ext_new    = ext_set & ~ext_flag_q;
  assign int_clr    = (reg_we_i && reg_addr_i == A_ICLR) ? reg_wdata_i[NI-1:0] : '0;
  assign ext_clr    = (reg_we_i && reg_addr_i == A_ECLR) ? reg_wdata_i[NUM_EXT-1:0] : '0;

  for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
    logic [FILT_LEN-1:0] hist_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni || !ext_en_q[j]) hist_q <= '0;
      else if (ext_sample_i)       hist_q <= {hist_q[FILT_LEN-2:0], ext_pin_i[j] ^ ext_ref_i[j]};
    end
    assign ext_set[j] = ext_en_q[j] && ($countones(hist_q) >= FILT_HITS);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      int_en_q <= '0; int_ne_q <= '0; ext_en_q <= '0; ext_ne_q <= '0;
      ovr_q <= 1'b0; bkopt_q <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_IEN: int_en_q <= reg_wdata_i[NI-1:0] & RSV_MASK;
        A_INE: int_ne_q <= reg_wdata_i[NI-1:0];
        A_EEN: ext_en_q <= reg_wdata_i[NUM_EXT-1:0];
        A_ENE: ext_ne_q <= reg_wdata_i[NUM_EXT-1:0];
        A_CTL: begin ovr_q <= reg_wdata_i[0]; bkopt_q <= reg_wdata_i[1]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      int_flag_q <= '0; int_pot_q <= '0; ext_flag_q <= '0; ext_pot_q <= '0;
      erase_q <= 1'b0; bkram_q <= 1'b0; ts_q <= 1'b0;
    end else begin
      int_flag_q <= int_set | (int_flag_q & ~int_clr);
      int_pot_q  <= (int_new & int_ne_eff) | (int_pot_q & ~(int_clr & ~int_set));
      ext_flag_q <= ext_set | (ext_flag_q & ~ext_clr);
      ext_pot_q  <= (ext_new & ext_ne_q) | (ext_pot_q & ~(ext_clr & ~ext_set));
      erase_q    <= |(int_new & ~int_ne_eff) | |(ext_new & ~ext_ne_q);
      bkram_q    <= bkopt_q & (|(int_new & ~int_ne_eff) | |(ext_new & ~ext_ne_q));
      ts_q       <= |int_new | |ext_new;
    end
  end

  assign block_o       = any_pot & ~ovr_q;
  assign store_wr_o    = store_wr_i & ~block_o;
  assign store_rdata_o = block_o ? '0 : store_rdata_i;
  assign erase_o       = erase_q;
  assign erase_bkram_o = bkram_q;
  assign ts_strobe_o   = ts_q;

  always_comb begin
    case (reg_addr_i)
      A_IEN:   reg_rdata_o = DW'(int_en_q);
      A_INE:   reg_rdata_o = DW'(int_ne_q);
      A_EEN:   reg_rdata_o = DW'(ext_en_q);
      A_ENE:   reg_rdata_o = DW'(ext_ne_q);
      A_CTL:   reg_rdata_o = DW'({bkopt_q, ovr_q});
      A_IFL:   reg_rdata_o = DW'(int_flag_q);
      A_EFL:   reg_rdata_o = DW'(ext_flag_q);
      default: reg_rdata_o = '0;
    endcase
  end

  a_r3_erase_has_confirmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (|(int_flag_q & ~int_pot_q) || |(ext_flag_q & ~ext_pot_q)));
  a_r4_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_flag_q[RSV]);
  a_r5_escalation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_fire_i && any_pot) |=> (int_flag_q[ESC] && !int_pot_q[ESC]));
  a_r6_store_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> (!store_wr_o && store_rdata_o == '0));
  a_r7_strobe_with_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> ts_strobe_o);
  a_r8_bkram_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_bkram_o |-> erase_o);
  a_r9_sticky_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_ICLR) |=> ((int_flag_q & $past(int_flag_q)) == $past(int_flag_q)));
  a_r9_sticky_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_ECLR) |=> ((ext_flag_q & $past(ext_flag_q)) == $past(ext_flag_q)));
endmodule

// File: tb/tamper_event_mgr_bench.sv
module tamper_event_mgr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] int_tamp = '0;
  logic [3:0]  ext_pin = '0, ext_ref = '0;
  logic        ext_sample = 1'b0, wdog = 1'b0, we = 1'b0, store_wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] store_rd = 32'hA5A5_0F0F;
  logic [15:0] rdata;
  logic        st_wr_o, blk, erase, bkram, ts;
  logic [31:0] st_rd_o;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  tamper_event_mgr u_tamper_event_mgr (
    .clk_i(clk), .rst_ni(rst_n), .int_tamp_i(int_tamp), .ext_pin_i(ext_pin), .ext_ref_i(ext_ref),
    .ext_sample_i(ext_sample), .wdog_fire_i(wdog), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .store_wr_i(store_wr), .store_rdata_i(store_rd),
    .store_wr_o(st_wr_o), .store_rdata_o(st_rd_o), .block_o(blk), .erase_o(erase),
    .erase_bkram_o(bkram), .ts_strobe_o(ts));

  logic [10:0] m_ien, m_ine, m_ifl, m_ipot;
  logic [3:0]  m_een, m_ene, m_efl, m_epot;
  logic        m_ovr, m_bko, m_erase, m_bk, m_ts;
  logic [3:0]  m_hist [4];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_anypot();
    return |(m_ifl & m_ipot) || |(m_efl & m_epot);
  endfunction

  always @(posedge clk) begin : model
    logic [10:0] iset;
    logic [3:0] eset;
    logic ap;
    if (!rst_n) begin
      m_ien = '0; m_ine = '0; m_ifl = '0; m_ipot = '0; m_een = '0; m_ene = '0;
      m_efl = '0; m_epot = '0; m_ovr = 0; m_bko = 0; m_erase = 0; m_bk = 0; m_ts = 0;
      for (int j = 0; j < 4; j++) m_hist[j] = '0;
    end else begin
      ap = m_anypot();
      for (int i = 0; i < 11; i++) iset[i] = (i != 9) && m_ien[i] && int_tamp[i];
      if (wdog && ap) iset[10] = 1'b1;
      for (int j = 0; j < 4; j++) eset[j] = m_een[j] && ($countones(m_hist[j]) >= 2);
      m_erase = 0; m_ts = 0;
      for (int i = 0; i < 11; i++) begin
        if (iset[i] && !m_ifl[i]) begin
          m_ts = 1; m_ifl[i] = 1; m_ipot[i] = (i != 10) && m_ine[i];
          if (!m_ipot[i]) m_erase = 1;
        end else if (!iset[i] && we && addr == 7 && wdata[i]) begin
          m_ifl[i] = 0; m_ipot[i] = 0;
        end
      end
      for (int j = 0; j < 4; j++) begin
        if (eset[j] && !m_efl[j]) begin
          m_ts = 1; m_efl[j] = 1; m_epot[j] = m_ene[j];
          if (!m_ene[j]) m_erase = 1;
        end else if (!eset[j] && we && addr == 8 && wdata[j]) begin
          m_efl[j] = 0; m_epot[j] = 0;
        end
        if (!m_een[j]) m_hist[j] = '0;
        else if (ext_sample) m_hist[j] = {m_hist[j][2:0], ext_pin[j] ^ ext_ref[j]};
      end
      m_bk = m_erase && m_bko;
      if (we) case (addr)
        0: m_ien = wdata[10:0] & 11'h5FF;
        1: m_ine = wdata[10:0];
        2: m_een = wdata[3:0];
        3: m_ene = wdata[3:0];
        4: begin m_ovr = wdata[0]; m_bko = wdata[1]; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin : compare
    logic eb;
    logic [15:0] er;
    if (rst_n) begin
      eb = m_anypot() && !m_ovr;
      case (addr)
        0: er = 16'(m_ien); 1: er = 16'(m_ine); 2: er = 16'(m_een); 3: er = 16'(m_ene);
        4: er = 16'({m_bko, m_ovr}); 5: er = 16'(m_ifl); 6: er = 16'(m_efl);
        default: er = '0;
      endcase
      chk("R6 block", blk, eb);
      chk("R6 store write", st_wr_o, store_wr && !eb);
      chk("R6 store read", st_rd_o, eb ? 0 : store_rd);
      chk("R3 erase", erase, m_erase);
      chk("R8 bkram erase", bkram, m_bk);
      chk("R7 timestamp", ts, m_ts);
      chk("R11 rdata", rdata, er);
    end
  end

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    we = 1; addr = a; wdata = d; cyc(); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    addr = a; @(negedge clk); chk(tag, rdata, exp); cyc();
  endtask

  task automatic sample(input logic [3:0] pins);
    ext_pin = pins; ext_sample = 1; cyc(); ext_sample = 0; ext_pin = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc();
    @(negedge clk);
    chk("R9 reset block", blk, 0); chk("R3 reset erase", erase, 0);
    cyc();
    int_tamp[0] = 1; cyc(3); int_tamp = '0;
    rd(4'd5, 16'h000, "R1 disabled source");
    wr(4'd0, 16'h7FF);
    rd(4'd0, 16'h5FF, "R4 reserved enable");
    wr(4'd1, 16'h40F);
    rd(4'd3, 16'h000, "R11 ext no-erase reset");
    int_tamp[4] = 1; cyc(); int_tamp = '0; cyc();
    rd(4'd5, 16'h010, "R2 confirmed flag");
    int_tamp[9] = 1; cyc(3); int_tamp = '0;
    rd(4'd5, 16'h010, "R4 reserved flag");
    int_tamp[1] = 1; cyc(2); store_wr = 1;
    @(negedge clk); chk("R6 blocked write", st_wr_o, 0); chk("R2 potential blocks", blk, 1);
    cyc();
    wr(4'd4, 16'h1);
    @(negedge clk); chk("R6 override write", st_wr_o, 1);
    cyc(); store_wr = 0;
    wr(4'd4, 16'h0);
    wdog = 1; cyc(); wdog = 0; cyc();
    rd(4'd5, 16'h412, "R5 escalation");
    wr(4'd4, 16'h2);
    int_tamp[5] = 1; cyc(); int_tamp[5] = 0; cyc();
    rd(4'd5, 16'h432, "R8 option event");
    wr(4'd7, 16'h7FF);
    rd(4'd5, 16'h002, "R9 set wins");
    int_tamp = '0; wr(4'd7, 16'h7FF);
    rd(4'd5, 16'h000, "R9 cleared");
    wr(4'd2, 16'h3); wr(4'd3, 16'h2);
    sample(4'h1); sample(4'h0); sample(4'h0); sample(4'h0); sample(4'h1); cyc(2);
    rd(4'd6, 16'h0, "R10 single hit");
    sample(4'h0); sample(4'h1); cyc(2);
    rd(4'd6, 16'h1, "R10 two in window");
    sample(4'h2); sample(4'h2); cyc(2);
    rd(4'd6, 16'h3, "R10 potential pin");
    @(negedge clk); chk("R6 ext potential blocks", blk, 1);
    wr(4'd2, 16'h0); wr(4'd8, 16'hF); cyc(2);
    rd(4'd6, 16'h0, "R9 ext cleared");
    cyc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule